// File: doc/BRIEF.md
# Plane Pixel Word Unpacker

This block takes one pixel word fetched for a graphics plane and rewrites it as a normalized 32-bit pixel with 8 bits each for alpha, red, green and blue. A 5-bit format code selects how the fields are laid out in the word. Three flags refine the reading:

- a byte-order flag reverses the component order;
- an alpha-position flag moves alpha to the other end of the word;
- an alpha-range flag selects whether an 8-bit alpha uses 0..255 or 0..128.

Narrow colour and alpha fields are widened to 8 bits. Formats without alpha come out opaque.

Both sides are valid/ready streams joined by a single register stage. A word is taken when `in_valid` and `in_ready` are both high. Its result shows on `out_argb` with `out_valid` one cycle later. While `out_valid` is high and `out_ready` is low, the output holds still and `in_ready` is low. `in_ready` is high whenever the stage is empty or the downstream consumer takes the held pixel in the same cycle. The sideband pins (`fmt_code`, `swap_order`, `alpha_swap`, `alpha_full`) are sampled together with `in_word`.

Top module: `pixel_unpack`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: A word accepted in one cycle gives `out_valid` high in the next cycle. While `out_valid` is high and `out_ready` is low, `out_argb` and `out_valid` stay unchanged and `in_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R3: Code 0x00 (16-bit 5:6:5) reads red from bits 15:11, green from bits 10:5 and blue from bits 4:0. A 5-bit field v becomes {v, v[4:2]} and a 6-bit field becomes {v, v[5:4]}. Alpha is 0xFF.
- R4: Code 0x01 (24-bit 8:8:8) reads red from bits 23:16, green from bits 15:8 and blue from bits 7:0. Bits 31:24 are ignored and alpha is 0xFF.
- R5: Code 0x02 (8:8:8 held in 32 bits) reads colour as in R6. The spare byte is ignored and alpha is always 0xFF.
- R6: For codes 0x02 and 0x05, let b3..b0 be the bytes of the word from most to least significant. The sequence s0..s3 is b3,b2,b1,b0 when `swap_order` is clear and b0,b1,b2,b3 when it is set. With `alpha_swap` clear, alpha, red, green and blue are s0, s1, s2 and s3. With `alpha_swap` set, red, green, blue and alpha are s0, s1, s2 and s3. So setting both flags gives alpha in b3 and red in b0.
- R7: Code 0x04 (24-bit 8:5:6:5) reads alpha from bits 23:16 and red, green and blue from bits 15:0 as in R3. Alpha is scaled by R9.
- R8: Code 0x05 (32-bit 8:8:8:8) takes its fields per R6 and scales alpha by R9.
- R9: `alpha_full` applies only to the 8-bit alpha of codes 0x04 and 0x05. When it is set, alpha passes unchanged. When it is clear, alpha a becomes 2a, saturated to 0xFF.
- R10: Code 0x06 (1:5:5:5) gives alpha 0xFF when bit 15 is 1 and 0x00 otherwise. Red is bits 14:10, green bits 9:5 and blue bits 4:0, each widened as in R3.
- R11: Code 0x07 (4:4:4:4) reads alpha, red, green and blue from bits 15:12, 11:8, 7:4 and 3:0. Each nibble n becomes {n, n}.
- R12: Code 0x03 and codes 0x08 to 0x1F give 0xFF000000 (opaque black).
- R13: `swap_order` and `alpha_swap` have no effect on any code other than 0x02 and 0x05.

The output word is {alpha, red, green, blue}, with alpha in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel word is valid |
| in_ready | output | 1 | Block can take an input word |
| in_word | input | 32 | Raw pixel word |
| fmt_code | input | 5 | Pixel format code |
| swap_order | input | 1 | Reverse component byte order (codes 0x02, 0x05) |
| alpha_swap | input | 1 | Alpha at the opposite end of the word (codes 0x02, 0x05) |
| alpha_full | input | 1 | 8-bit alpha uses the full 0..255 range |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_argb | output | 32 | Normalized pixel {A,R,G,B} |

## Verification
Every converted pixel is due exactly one rising edge after the edge at which its word is accepted. The bench therefore sets its inputs at a falling edge and reads `out_valid` and `out_argb` at the next falling edge, with exactly one register update in between. For the back-pressure case, the bench reads the held output at each falling edge while `out_ready` is low. It then expects the next word one falling edge after `out_ready` rises, because the stage frees and reloads at the same edge.

// File: rtl/pxu_pkg.sv
`timescale 1ns/1ps
package pxu_pkg;

  typedef enum logic [2:0] {
    PF_RGB565   = 3'd0,
    PF_RGB888   = 3'd1,
    PF_XRGB32   = 3'd2,
    PF_ARGB8565 = 3'd3,
    PF_ARGB32   = 3'd4,
    PF_ARGB1555 = 3'd5,
    PF_ARGB4444 = 3'd6,
    PF_UNKNOWN  = 3'd7
  } pix_fmt_e;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  // bit-replicating widening keeps 0 -> 0x00 and max -> 0xFF
  function automatic logic [7:0] grow5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] grow6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [7:0] grow4(input logic [3:0] v);
    return {v, v};
  endfunction

  // half-range alpha: double, saturating at 0xFF
  function automatic logic [7:0] scale_alpha(input logic [7:0] a, input logic full);
    if (full)      return a;
    else if (a[7]) return 8'hFF;
    else           return {a[6:0], 1'b0};
  endfunction

endpackage

// File: rtl/pxu_fmt_decode.sv
`timescale 1ns/1ps
module pxu_fmt_decode #(
  parameter int FMT_W = 5
) (
  input  logic [FMT_W-1:0]     code,
  output pxu_pkg::pix_fmt_e    fmt,
  output logic                 unknown
);
  import pxu_pkg::*;

  always_comb begin
    case (code)
      FMT_W'(0): fmt = PF_RGB565;
      FMT_W'(1): fmt = PF_RGB888;
      FMT_W'(2): fmt = PF_XRGB32;
      FMT_W'(4): fmt = PF_ARGB8565;
      FMT_W'(5): fmt = PF_ARGB32;
      FMT_W'(6): fmt = PF_ARGB1555;
      FMT_W'(7): fmt = PF_ARGB4444;
      default:   fmt = PF_UNKNOWN;
    endcase
  end

  assign unknown = (fmt == PF_UNKNOWN);

endmodule

// File: rtl/pxu_field_unpack.sv
`timescale 1ns/1ps
module pxu_field_unpack #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]  word,
  input  pxu_pkg::pix_fmt_e  fmt,
  input  logic               swap_order,
  input  logic               alpha_swap,
  input  logic               alpha_full,
  output pxu_pkg::argb_t     px
);
  import pxu_pkg::*;

  localparam int LANES = DATA_W / 8;

  logic [7:0] lane [LANES];

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign lane[gi] = word[8*gi +: 8];
    end
  endgenerate

  logic [7:0] s0, s1, s2, s3;
  argb_t      wide;

  // component order for the 32-bit layouts
  always_comb begin
    if (swap_order) begin
      s0 = lane[0]; s1 = lane[1]; s2 = lane[2]; s3 = lane[3];
    end else begin
      s0 = lane[3]; s1 = lane[2]; s2 = lane[1]; s3 = lane[0];
    end
    if (alpha_swap) begin
      wide.r = s0; wide.g = s1; wide.b = s2; wide.a = s3;
    end else begin
      wide.a = s0; wide.r = s1; wide.g = s2; wide.b = s3;
    end
  end

  always_comb begin
    px = '{a: 8'hFF, r: 8'h00, g: 8'h00, b: 8'h00};
    case (fmt)
      PF_RGB565: begin
        px.r = grow5(word[15:11]);
        px.g = grow6(word[10:5]);
        px.b = grow5(word[4:0]);
      end
      PF_RGB888: begin
        px.r = lane[2];
        px.g = lane[1];
        px.b = lane[0];
      end
      PF_XRGB32: begin
        px.r = wide.r;
        px.g = wide.g;
        px.b = wide.b;
      end
      PF_ARGB8565: begin
        px.a = scale_alpha(lane[2], alpha_full);
        px.r = grow5(word[15:11]);
        px.g = grow6(word[10:5]);
        px.b = grow5(word[4:0]);
      end
      PF_ARGB32: begin
        px   = wide;
        px.a = scale_alpha(wide.a, alpha_full);
      end
      PF_ARGB1555: begin
        px.a = {8{word[15]}};
        px.r = grow5(word[14:10]);
        px.g = grow5(word[9:5]);
        px.b = grow5(word[4:0]);
      end
      PF_ARGB4444: begin
        px.a = grow4(word[15:12]);
        px.r = grow4(word[11:8]);
        px.g = grow4(word[7:4]);
        px.b = grow4(word[3:0]);
      end
      default: px = '{a: 8'hFF, r: 8'h00, g: 8'h00, b: 8'h00};
    endcase
  end

endmodule

// File: rtl/pxu_out_stage.sv
`timescale 1ns/1ps
module pxu_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  // R2: a stalled output keeps its pixel
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2: an accepted word shows up one cycle later
  assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/pixel_unpack.sv
`timescale 1ns/1ps
module pixel_unpack #(
  parameter int DATA_W = 32,
  parameter int FMT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_word,
  input  logic [FMT_W-1:0]  fmt_code,
  input  logic              swap_order,
  input  logic              alpha_swap,
  input  logic              alpha_full,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_argb
);
  import pxu_pkg::*;

  localparam int PIX_W = $bits(argb_t);

  pix_fmt_e fmt;
  logic     fmt_unknown;
  argb_t    px;

  pxu_fmt_decode #(.FMT_W(FMT_W)) u_dec (
    .code    (fmt_code),
    .fmt     (fmt),
    .unknown (fmt_unknown)
  );

  pxu_field_unpack #(.DATA_W(DATA_W)) u_unpack (
    .word       (in_word),
    .fmt        (fmt),
    .swap_order (swap_order),
    .alpha_swap (alpha_swap),
    .alpha_full (alpha_full),
    .px         (px)
  );

  pxu_out_stage #(.W(PIX_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (px),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_argb)
  );

  // R12: unknown codes give opaque black
  assert_black_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && fmt_unknown) |=> (out_argb == 32'hFF00_0000));

  // R5: the padded 32-bit colour layout is always opaque
  assert_opaque_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && fmt == PF_XRGB32) |=> (out_argb[31:24] == 8'hFF));

  // R10: a one-bit alpha is either fully clear or fully set
  assert_alpha1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && fmt == PF_ARGB1555)
      |=> (out_argb[31:24] == 8'h00 || out_argb[31:24] == 8'hFF));

endmodule

// File: tb/pixel_unpack_test.sv
`timescale 1ns/1ps
module pixel_unpack_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [4:0]  fmt_code = '0;
  logic        swap_order = 1'b0;
  logic        alpha_swap = 1'b0;
  logic        alpha_full = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_argb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pixel_unpack uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .fmt_code(fmt_code), .swap_order(swap_order),
    .alpha_swap(alpha_swap), .alpha_full(alpha_full), .out_valid(out_valid),
    .out_ready(out_ready), .out_argb(out_argb)
  );

  function automatic int w5(input int v); return v * 8 + v / 4; endfunction
  function automatic int w6(input int v); return v * 4 + v / 16; endfunction
  function automatic int w4(input int v); return v * 17; endfunction
  function automatic int asc(input int v, input bit full);
    if (full) return v;
    return (2 * v > 255) ? 255 : 2 * v;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] w, input int code,
                                        input bit sw, input bit asw, input bit full);
    int a, r, g, b;
    int bt [4];
    int s [4];
    for (int i = 0; i < 4; i++) bt[i] = (w >> (8 * i)) & 255;
    for (int i = 0; i < 4; i++) s[i] = sw ? bt[i] : bt[3 - i];
    a = 255; r = 0; g = 0; b = 0;
    case (code)
      0: begin r = w5((w >> 11) & 31); g = w6((w >> 5) & 63); b = w5(w & 31); end
      1: begin r = bt[2]; g = bt[1]; b = bt[0]; end
      2, 5: begin
        if (asw) begin r = s[0]; g = s[1]; b = s[2]; a = s[3]; end
        else     begin a = s[0]; r = s[1]; g = s[2]; b = s[3]; end
        a = (code == 2) ? 255 : asc(a, full);
      end
      4: begin
        a = asc(bt[2], full);
        r = w5((w >> 11) & 31); g = w6((w >> 5) & 63); b = w5(w & 31);
      end
      6: begin
        a = w[15] ? 255 : 0;
        r = w5((w >> 10) & 31); g = w5((w >> 5) & 31); b = w5(w & 31);
      end
      7: begin
        a = w4((w >> 12) & 15); r = w4((w >> 8) & 15);
        g = w4((w >> 4) & 15);  b = w4(w & 15);
      end
      default: begin a = 255; r = 0; g = 0; b = 0; end
    endcase
    return {a[7:0], r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic string tag_for(input int code, input int flags);
    if ((code == 2 || code == 5) && (flags & 3) != 0) return "R6";
    if (code != 2 && code != 5 && (flags & 3) != 0) return "R13";
    case (code)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      4: return "R7";
      5: return "R8";
      6: return "R10";
      7: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one transfer: drive at a falling edge, read at the next falling edge
  task automatic send(input logic [31:0] w, input int code, input int flags, input string req);
    @(negedge clk);
    in_word = w; fmt_code = code[4:0];
    swap_order = flags[0]; alpha_swap = flags[1]; alpha_full = flags[2];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, out_argb, model(w, code, flags[0], flags[1], flags[2]));
  endtask

  logic [31:0] pats [6];

  initial begin
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h1234_5678;
    pats[3] = 32'hA5C3_7E81; pats[4] = 32'h807F_01FE; pats[5] = 32'h0FF0_55AA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", {31'd0, in_ready}, 32'd1);

    // sweep every code, flag combination and pattern (R3..R8, R10..R13)
    for (int c = 0; c < 32; c++)
      for (int f = 0; f < 8; f++)
        for (int p = 0; p < 6; p++)
          send(pats[p], c, f, tag_for(c, f));

    // R9: every alpha value in both ranges, codes 0x04 and 0x05
    for (int a = 0; a < 256; a++) begin
      send({a[7:0], 24'h3C_5A_96}, 5, 4, "R9");
      send({a[7:0], 24'h3C_5A_96}, 5, 0, "R9");
      send({8'h00, a[7:0], 16'hBEEF}, 4, 0, "R9");
    end

    // R2: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_word = 32'h11223344; fmt_code = 5'd5;
    swap_order = 1'b0; alpha_swap = 1'b0; alpha_full = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_word = 32'h0000F00F; fmt_code = 5'd7;
    check("R2", {31'd0, out_valid}, 32'd1);
    check("R2", {31'd0, in_ready}, 32'd0);
    check("R2", out_argb, 32'h11223344);
    @(negedge clk);
    check("R2", out_argb, 32'h11223344);
    check("R2", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {31'd0, out_valid}, 32'd1);
    check("R2", out_argb, 32'hFF0000FF);
    @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule